// File: doc/BRIEF.md
# Write-Back MESI Snoop Controller

This block sits beside one core's cache on a shared split-transaction bus and keeps that cache's line states coherent under a four-state write-back protocol. It holds the tag and state table for a direct-mapped cache. It watches every request and every completion that other masters put on the bus, and it moves local lines to Shared or Invalid when their copies go stale. The data arrays are outside the block.

A request from another master that hits a locally Modified line is aborted in its own request cycle. The controller then tells its core to write the dirty line back to memory. Only one such forced write-back is open at a time. When the core's own write for that line completes, the line drops to Shared if a read caused the write-back, or to Invalid if a write or write-intent caused it. The requester then retries and reads current data from memory. During another master's read request, the controller also drives a shared indication, so the requester can fill as Exclusive or as Shared.

The core and the snooper share the write port of the table through a mutual-exclusion lock register. State changes from the snooper wait in an ordered queue while the core holds the lock.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid, and `snoop_abort`, `snoop_shared`, `wb_cmd_valid` and `core_lock_gnt` are all 0.
- R2: Line states are encoded as Modified=2'b11, Exclusive=2'b10, Shared=2'b01 and Invalid=2'b00. During a valid READ request (kind 2'b00) from another master, `snoop_shared` is 1 in the same cycle exactly when the addressed line is held in any valid state. For any other request it is 0.
- R3: A request of kind READ (2'b00), WRITE (2'b01) or INTENT (2'b10) from another master that hits a Modified line raises `snoop_abort` combinationally in that request cycle. Requests to lines that are not Modified are not aborted.
- R4: If no write-back is open, the first abort opens one. `wb_cmd_valid` is 1 from the next cycle, and `wb_cmd_addr` gives the line-aligned address of the aborted request.
- R5: Only one write-back is open at a time. While one is open, further Modified hits are still aborted, but the command address stays the same. A retry after the write-back closes opens a new one.
- R6: A write-back closes on a completion of kind WRITE from the local master (`LOCAL_ID`) for the commanded line. `wb_cmd_valid` then drops after that edge, and the line becomes Shared if a READ triggered the write-back, or Invalid if a WRITE or INTENT triggered it.
- R7: When another master's READ completes on a local Exclusive or Shared line, that line becomes Shared. When another master's WRITE or INTENT completes on any valid local line, that line becomes Invalid.
- R8: The following do not change any line state: completions whose tag does not match the stored tag, completions of kind 2'b11, and completions from the local master other than the commanded write-back. Requests from the local master never assert `snoop_shared` or `snoop_abort`.
- R9: A core lock request is granted one cycle after it is raised when no snoop update is waiting. Writes from the core to the table take effect only while it holds the grant.
- R10: Snoop updates that arrive while the core holds the lock are held, up to `PEND_DEPTH` of them. They are applied in order after the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_valid | input | 1 | A request phase ends this cycle |
| bus_req_master | input | MID_W | Master issuing the request |
| bus_req_kind | input | 2 | 00 read, 01 write, 10 write-intent, 11 none |
| bus_req_addr | input | ADDR_W | Request byte address |
| bus_done_valid | input | 1 | A response or acknowledge phase ends this cycle |
| bus_done_master | input | MID_W | Master whose transaction completes |
| bus_done_kind | input | 2 | Kind of the completing transaction |
| bus_done_addr | input | ADDR_W | Byte address of the completing transaction |
| snoop_abort | output | 1 | Abort the current request (Modified hit) |
| snoop_shared | output | 1 | Line is held locally during another master's read |
| wb_cmd_valid | output | 1 | Command to the core to write the line back |
| wb_cmd_addr | output | ADDR_W | Line-aligned address to write back |
| core_lock_req | input | 1 | Core asks for the table lock |
| core_lock_gnt | output | 1 | Core holds the table lock |
| core_wr_en | input | 1 | Core writes a tag and state entry |
| core_wr_addr | input | ADDR_W | Address for the core write |
| core_wr_state | input | 2 | New state for the core write |
| core_rd_addr | input | ADDR_W | Address for the core state lookup |
| core_rd_state | output | 2 | State of that line, or Invalid on tag mismatch |

## Verification
The closing of a write-back and a new conflicting request can fall in the same cycle. The bench drives the local master's WRITE completion for the commanded line in the same cycle as another master's READ to a second Modified line. The new read must be aborted, and no new command may appear after the edge: the write-back is still counted as open when the request is decided. A retry must then open a write-back for the second line, and the first line must settle in the state its trigger selects. The bench also lets snoop completions arrive while the core holds the lock, and checks that they are held back and then applied once the lock is released.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_state_t;

   typedef enum logic [1:0] {
      BK_READ   = 2'b00,
      BK_WRITE  = 2'b01,
      BK_INTENT = 2'b10,
      BK_NONE   = 2'b11
   } bus_kind_t;

   typedef enum logic [1:0] {
      UP_SHARE    = 2'b00,
      UP_DROP     = 2'b01,
      UP_WB_SHARE = 2'b10,
      UP_WB_DROP  = 2'b11
   } upd_kind_t;

   typedef enum logic [1:0] {
      OWN_FREE  = 2'b00,
      OWN_CORE  = 2'b01,
      OWN_SNOOP = 2'b10
   } lock_owner_t;

   // next state of a hitting line under one queued snoop update
   function automatic logic [1:0] next_line_state(input logic [1:0] cur,
                                                  input logic [1:0] kind);
      logic [1:0] nxt;
      nxt = cur;
      if (cur != ST_I) begin
         case (kind)
            UP_SHARE:    if (cur == ST_E || cur == ST_S) nxt = ST_S;
            UP_DROP:     nxt = ST_I;
            UP_WB_SHARE: if (cur == ST_M) nxt = ST_S;
            default:     nxt = ST_I;
         endcase
      end
      return nxt;
   endfunction

endpackage

// File: rtl/mesi_tag_table.sv
module mesi_tag_table #(
   parameter int SETS   = 8,
   parameter int LINE_W = 12,
   parameter int NRD    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NRD-1:0][LINE_W-1:0]  rd_line,
   output logic [NRD-1:0][1:0]         rd_state,
   input  logic                        wr_en,
   input  logic [LINE_W-1:0]           wr_line,
   input  logic [1:0]                  wr_state
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = LINE_W - IDX_W;

   generate
      if (SETS < 2 || (1 << IDX_W) != SETS)
         $error("mesi_tag_table: SETS must be a power of two, at least 2");
      if (TAG_W < 1)
         $error("mesi_tag_table: line address leaves no tag bits");
   endgenerate

   logic [TAG_W-1:0] tag_q [SETS];
   logic [1:0]       st_q  [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tag_q[s] <= '0;
            st_q[s]  <= 2'b00;
         end
      end else if (wr_en) begin
         tag_q[wr_line[IDX_W-1:0]] <= wr_line[LINE_W-1:IDX_W];
         st_q[wr_line[IDX_W-1:0]]  <= wr_state;
      end
   end

   // independent lookup ports, one per consumer
   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         logic [IDX_W-1:0] idx;
         assign idx = rd_line[p][IDX_W-1:0];
         assign rd_state[p] = (tag_q[idx] == rd_line[p][LINE_W-1:IDX_W])
                              ? st_q[idx] : 2'b00;
      end
   endgenerate

endmodule

// File: rtl/mesi_pend_fifo.sv
module mesi_pend_fifo #(
   parameter int W     = 14,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 1)
         $error("mesi_pend_fifo: DEPTH must be at least 1");

      if (DEPTH == 1) begin : g_single
         logic         vld_q;
         logic [W-1:0] dat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               if (push) begin
                  vld_q <= 1'b1;
                  dat_q <= push_data;
               end else if (pop) begin
                  vld_q <= 1'b0;
               end
            end
         end
         assign head  = dat_q;
         assign empty = !vld_q;
         assign full  = vld_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         logic [W-1:0]     mem_q [DEPTH];
         logic [PTR_W-1:0] rd_q, wr_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_push, do_pop;

         assign do_pop  = pop && (cnt_q != '0);
         assign do_push = push && (cnt_q != CNT_W'(DEPTH) || do_pop);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (do_push) begin
                  mem_q[wr_q] <= push_data;
                  wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
               end
               if (do_pop)
                  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
               cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
            end
         end
         assign head  = mem_q[rd_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CNT_W'(DEPTH));
      end
   endgenerate

   // R10: the queue is sized so no update is ever lost
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

endmodule

// File: rtl/mesi_lock_reg.sv
module mesi_lock_reg
   import mesi_snoop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       core_req,
   input  logic       snoop_need,
   output logic [1:0] owner
);
   logic [1:0] own_q, own_d;

   always_comb begin
      own_d = own_q;
      case (own_q)
         OWN_FREE:
            if (snoop_need)    own_d = OWN_SNOOP;
            else if (core_req) own_d = OWN_CORE;
         OWN_CORE:
            if (!core_req)     own_d = snoop_need ? OWN_SNOOP : OWN_FREE;
         OWN_SNOOP:
            if (!snoop_need)   own_d = core_req ? OWN_CORE : OWN_FREE;
         default:              own_d = OWN_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) own_q <= OWN_FREE;
      else        own_q <= own_d;
   end

   assign owner = own_q;

   // R9: the core is never handed the lock while it is not asking for it
   p_core_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_FREE && !core_req) |=> own_q != OWN_CORE);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_snoop_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 8,
   parameter int MID_W      = 2,
   parameter int LOCAL_ID   = 0,
   parameter int PEND_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req_valid,
   input  logic [MID_W-1:0]  bus_req_master,
   input  logic [1:0]        bus_req_kind,
   input  logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_done_valid,
   input  logic [MID_W-1:0]  bus_done_master,
   input  logic [1:0]        bus_done_kind,
   input  logic [ADDR_W-1:0] bus_done_addr,
   output logic              snoop_abort,
   output logic              snoop_shared,
   output logic              wb_cmd_valid,
   output logic [ADDR_W-1:0] wb_cmd_addr,
   input  logic              core_lock_req,
   output logic              core_lock_gnt,
   input  logic              core_wr_en,
   input  logic [ADDR_W-1:0] core_wr_addr,
   input  logic [1:0]        core_wr_state,
   input  logic [ADDR_W-1:0] core_rd_addr,
   output logic [1:0]        core_rd_state
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int ENT_W  = LINE_W + 2;
   localparam int NRD    = 4;
   localparam logic [MID_W-1:0] ME = MID_W'(LOCAL_ID);

   generate
      if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 2)
         $error("mesi_snoop_ctrl: LINE_BYTES must be a power of two");
      if (LOCAL_ID >= (1 << MID_W))
         $error("mesi_snoop_ctrl: LOCAL_ID does not fit MID_W");
   endgenerate

   // ---------------- line addresses and table lookups ----------------
   logic [LINE_W-1:0] req_line, done_line, core_line, head_line;
   logic [1:0]        head_kind;
   logic [ENT_W-1:0]  head_ent;
   logic [NRD-1:0][LINE_W-1:0] rd_line;
   logic [NRD-1:0][1:0]        rd_state;

   assign req_line  = bus_req_addr[ADDR_W-1:OFF_W];
   assign done_line = bus_done_addr[ADDR_W-1:OFF_W];
   assign core_line = core_rd_addr[ADDR_W-1:OFF_W];
   assign head_line = head_ent[ENT_W-1:2];
   assign head_kind = head_ent[1:0];

   assign rd_line[0] = req_line;
   assign rd_line[1] = done_line;
   assign rd_line[2] = core_line;
   assign rd_line[3] = head_line;

   logic [1:0] req_st, done_st, head_st;
   assign req_st        = rd_state[0];
   assign done_st       = rd_state[1];
   assign core_rd_state = rd_state[2];
   assign head_st       = rd_state[3];

   // ---------------- request phase: abort and shared ----------------
   logic req_foreign;
   assign req_foreign = bus_req_valid && (bus_req_master != ME)
                        && (bus_req_kind != BK_NONE);
   assign snoop_abort  = req_foreign && (req_st == ST_M);
   assign snoop_shared = req_foreign && (bus_req_kind == BK_READ)
                         && (req_st != ST_I);

   // ---------------- forced write-back tracking ----------------
   logic              wb_busy_q, wb_share_q;
   logic [LINE_W-1:0] wb_line_q;
   logic              wb_closing;

   assign wb_closing = bus_done_valid && (bus_done_master == ME)
                       && (bus_done_kind == BK_WRITE) && wb_busy_q
                       && (done_line == wb_line_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_busy_q  <= 1'b0;
         wb_share_q <= 1'b0;
         wb_line_q  <= '0;
      end else if (wb_busy_q) begin
         if (wb_closing) wb_busy_q <= 1'b0;
      end else if (snoop_abort) begin
         wb_busy_q  <= 1'b1;
         wb_share_q <= (bus_req_kind == BK_READ);
         wb_line_q  <= req_line;
      end
   end

   assign wb_cmd_valid = wb_busy_q;
   assign wb_cmd_addr  = {wb_line_q, {OFF_W{1'b0}}};

   // ---------------- completion phase: queue state updates ----------------
   logic             done_foreign, q_push, q_pop, q_empty, q_full;
   logic [1:0]       push_kind;
   logic [ENT_W-1:0] push_ent;

   assign done_foreign = bus_done_valid && (bus_done_master != ME)
                         && (bus_done_kind != BK_NONE) && (done_st != ST_I);
   assign q_push = done_foreign || wb_closing;

   always_comb begin
      if (wb_closing)
         push_kind = wb_share_q ? UP_WB_SHARE : UP_WB_DROP;
      else if (bus_done_kind == BK_READ)
         push_kind = UP_SHARE;
      else
         push_kind = UP_DROP;
   end
   assign push_ent = {done_line, push_kind};

   logic [1:0] owner;

   mesi_pend_fifo #(.W(ENT_W), .DEPTH(PEND_DEPTH)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_data(push_ent),
      .pop(q_pop), .head(head_ent),
      .empty(q_empty), .full(q_full)
   );

   mesi_lock_reg u_lock (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_lock_req), .snoop_need(!q_empty),
      .owner(owner)
   );

   assign core_lock_gnt = (owner == OWN_CORE);

   // ---------------- table write port ----------------
   logic [1:0]        head_new;
   logic              snoop_wr, core_wr;
   logic              tbl_we;
   logic [LINE_W-1:0] tbl_line;
   logic [1:0]        tbl_state;

   assign q_pop    = (owner == OWN_SNOOP) && !q_empty;
   assign head_new = next_line_state(head_st, head_kind);
   assign snoop_wr = q_pop && (head_new != head_st);
   assign core_wr  = (owner == OWN_CORE) && core_wr_en;

   assign tbl_we    = snoop_wr || core_wr;
   assign tbl_line  = snoop_wr ? head_line : core_wr_addr[ADDR_W-1:OFF_W];
   assign tbl_state = snoop_wr ? head_new  : core_wr_state;

   mesi_tag_table #(.SETS(SETS), .LINE_W(LINE_W), .NRD(NRD)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_line(rd_line), .rd_state(rd_state),
      .wr_en(tbl_we), .wr_line(tbl_line), .wr_state(tbl_state)
   );

   // ---------------- assertions ----------------
   // R2: shared indication only accompanies a read request
   p_shared_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_shared |-> (bus_req_valid && bus_req_kind == BK_READ));

   // R3: only a foreign request may be aborted
   p_abort_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_abort |-> (bus_req_valid && bus_req_master != ME));

   // R4: a write-back command starts only after an abort
   p_cmd_after_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_cmd_valid) |-> $past(snoop_abort));

   // R5: the open command keeps its address until it closes
   p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cmd_valid && !wb_closing) |=> (wb_cmd_valid && $stable(wb_cmd_addr)));

   // R6: closing the write-back drops the command
   p_cmd_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_closing |=> !wb_cmd_valid);

   // R9: snooper and core never write the table together
   p_lock_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_lock_gnt && snoop_wr));

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req_valid = 1'b0;
   logic [1:0]    bus_req_master = '0;
   logic [1:0]    bus_req_kind = 2'b11;
   logic [AW-1:0] bus_req_addr = '0;
   logic          bus_done_valid = 1'b0;
   logic [1:0]    bus_done_master = '0;
   logic [1:0]    bus_done_kind = 2'b11;
   logic [AW-1:0] bus_done_addr = '0;
   logic          snoop_abort, snoop_shared, wb_cmd_valid, core_lock_gnt;
   logic [AW-1:0] wb_cmd_addr;
   logic          core_lock_req = 1'b0;
   logic          core_wr_en = 1'b0;
   logic [AW-1:0] core_wr_addr = '0;
   logic [1:0]    core_wr_state = '0;
   logic [AW-1:0] core_rd_addr = '0;
   logic [1:0]    core_rd_state;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
   localparam logic [1:0] RD = 2'b00, WR = 2'b01, IN = 2'b10, NO = 2'b11;
   localparam logic [AW-1:0] LA = 16'h0120, LB = 16'h0130, LC = 16'h0520;

   always #4 clk = ~clk;

   mesi_snoop_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .bus_req_valid(bus_req_valid), .bus_req_master(bus_req_master),
      .bus_req_kind(bus_req_kind), .bus_req_addr(bus_req_addr),
      .bus_done_valid(bus_done_valid), .bus_done_master(bus_done_master),
      .bus_done_kind(bus_done_kind), .bus_done_addr(bus_done_addr),
      .snoop_abort(snoop_abort), .snoop_shared(snoop_shared),
      .wb_cmd_valid(wb_cmd_valid), .wb_cmd_addr(wb_cmd_addr),
      .core_lock_req(core_lock_req), .core_lock_gnt(core_lock_gnt),
      .core_wr_en(core_wr_en), .core_wr_addr(core_wr_addr),
      .core_wr_state(core_wr_state),
      .core_rd_addr(core_rd_addr), .core_rd_state(core_rd_state)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [1:0] st);
      core_rd_addr = a;
      #1 st = core_rd_state;
   endtask

   task automatic core_set(input logic [AW-1:0] a, input logic [1:0] st);
      @(negedge clk);
      core_lock_req = 1'b1;
      @(negedge clk);
      while (!core_lock_gnt) @(negedge clk);
      core_wr_en = 1'b1; core_wr_addr = a; core_wr_state = st;
      @(negedge clk);
      core_wr_en = 1'b0; core_lock_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_req(input logic [1:0] m, input logic [1:0] k,
                          input logic [AW-1:0] a,
                          output logic ab, output logic sh);
      @(negedge clk);
      bus_req_valid = 1'b1; bus_req_master = m; bus_req_kind = k; bus_req_addr = a;
      #1 ab = snoop_abort; sh = snoop_shared;
      @(negedge clk);
      bus_req_valid = 1'b0; bus_req_kind = NO;
   endtask

   task automatic bus_done(input logic [1:0] m, input logic [1:0] k,
                           input logic [AW-1:0] a);
      @(negedge clk);
      bus_done_valid = 1'b1; bus_done_master = m; bus_done_kind = k; bus_done_addr = a;
      @(negedge clk);
      bus_done_valid = 1'b0; bus_done_kind = NO;
   endtask

   task automatic t_reset();
      logic [1:0] st;
      peek(LA, st);
      check("R1", "state after reset", st, I);
      check("R1", "abort after reset", snoop_abort, 0);
      check("R1", "shared after reset", snoop_shared, 0);
      check("R1", "wb cmd after reset", wb_cmd_valid, 0);
      check("R1", "grant after reset", core_lock_gnt, 0);
   endtask

   task automatic t_shared();
      logic ab, sh;
      core_set(LA, E);
      bus_req(2'd1, RD, LA, ab, sh);
      check("R2", "shared on read of E line", sh, 1);
      check("R3", "no abort on E line", ab, 0);
      bus_req(2'd1, WR, LA, ab, sh);
      check("R2", "shared on write request", sh, 0);
      bus_req(2'd2, RD, LB, ab, sh);
      check("R2", "shared on invalid line", sh, 0);
      bus_req(2'd0, RD, LA, ab, sh);
      check("R8", "shared on own request", sh, 0);
   endtask

   task automatic t_downgrade();
      logic [1:0] st;
      bus_done(2'd1, RD, LA);
      settle();
      peek(LA, st);
      check("R7", "E after foreign read completion", st, S);
      bus_done(2'd2, IN, LA);
      settle();
      peek(LA, st);
      check("R7", "S after foreign intent completion", st, I);
   endtask

   task automatic t_ignore();
      logic [1:0] st;
      core_set(LA, E);
      bus_done(2'd1, WR, LC);
      settle();
      peek(LA, st);
      check("R8", "tag mismatch write", st, E);
      bus_done(2'd1, NO, LA);
      settle();
      peek(LA, st);
      check("R8", "kind 11 completion", st, E);
      bus_done(2'd0, WR, LA);
      settle();
      peek(LA, st);
      check("R8", "own write without open write-back", st, E);
   endtask

   task automatic t_wb_read();
      logic ab, sh;
      logic [1:0] st;
      core_set(LB, M);
      bus_req(2'd1, RD, LB | 16'h0007, ab, sh);
      check("R3", "abort on M read", ab, 1);
      check("R2", "shared on M read", sh, 1);
      check("R4", "wb cmd raised", wb_cmd_valid, 1);
      check("R4", "wb cmd line address", wb_cmd_addr, LB);
      bus_req(2'd2, RD, LB, ab, sh);
      check("R3", "second read still aborted", ab, 1);
      bus_done(2'd0, WR, LB);
      check("R6", "wb cmd dropped", wb_cmd_valid, 0);
      settle();
      peek(LB, st);
      check("R6", "read-triggered wb leaves S", st, S);
      bus_req(2'd1, RD, LB, ab, sh);
      check("R3", "retry not aborted", ab, 0);
   endtask

   task automatic t_wb_intent();
      logic ab, sh;
      logic [1:0] st;
      core_set(LA, M);
      bus_req(2'd2, IN, LA, ab, sh);
      check("R3", "abort on M intent", ab, 1);
      check("R4", "wb cmd for intent", wb_cmd_addr, LA);
      bus_done(2'd0, WR, LA);
      settle();
      peek(LA, st);
      check("R6", "intent-triggered wb leaves I", st, I);
   endtask

   task automatic t_single_wb();
      logic ab, sh;
      logic [1:0] st;
      core_set(LA, M);
      core_set(LB, M);
      bus_req(2'd1, WR, LA, ab, sh);
      check("R3", "abort on M write", ab, 1);
      check("R4", "wb cmd for A", wb_cmd_addr, LA);
      bus_req(2'd2, RD, LB, ab, sh);
      check("R5", "B aborted while busy", ab, 1);
      check("R5", "cmd address kept", wb_cmd_addr, LA);
      // close A and see a conflicting read for B in the same cycle
      @(negedge clk);
      bus_done_valid = 1'b1; bus_done_master = 2'd0; bus_done_kind = WR; bus_done_addr = LA;
      bus_req_valid = 1'b1; bus_req_master = 2'd2; bus_req_kind = RD; bus_req_addr = LB;
      #1 ab = snoop_abort;
      @(negedge clk);
      bus_done_valid = 1'b0; bus_done_kind = NO;
      bus_req_valid = 1'b0; bus_req_kind = NO;
      check("R5", "abort in closing cycle", ab, 1);
      check("R5", "no new cmd in closing cycle", wb_cmd_valid, 0);
      settle();
      peek(LA, st);
      check("R6", "A after write-triggered wb", st, I);
      bus_req(2'd2, RD, LB, ab, sh);
      check("R5", "retry aborted", ab, 1);
      check("R5", "new cmd for B", wb_cmd_addr, LB);
      check("R5", "new cmd valid", wb_cmd_valid, 1);
      bus_done(2'd0, WR, LB);
      settle();
      peek(LB, st);
      check("R6", "B after read-triggered wb", st, S);
   endtask

   task automatic t_lock();
      logic [1:0] st;
      core_set(LA, E);
      core_set(LB, E);
      @(negedge clk);
      core_lock_req = 1'b1;
      @(negedge clk);
      check("R9", "grant one cycle after request", core_lock_gnt, 1);
      bus_done(2'd1, RD, LA);
      bus_done(2'd1, WR, LB);
      bus_done(2'd2, RD, LB);
      settle();
      peek(LA, st);
      check("R9", "A held while core locked", st, E);
      peek(LB, st);
      check("R9", "B held while core locked", st, E);
      core_lock_req = 1'b0;
      settle();
      check("R9", "grant released", core_lock_gnt, 0);
      peek(LA, st);
      check("R10", "A after release", st, S);
      peek(LB, st);
      check("R10", "B after release", st, I);
      // write without grant
      @(negedge clk);
      core_wr_en = 1'b1; core_wr_addr = LA; core_wr_state = M;
      @(negedge clk);
      core_wr_en = 1'b0;
      settle();
      peek(LA, st);
      check("R9", "core write without grant ignored", st, S);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shared();
      t_downgrade();
      t_ignore();
      t_wb_read();
      t_wb_intent();
      t_single_wb();
      t_lock();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule